// File: doc/BRIEF.md
# Management-Interrupt Entry and Resume Controller

This block takes an active-low, asynchronous management interrupt request for a small processor core. It decides when the core enters management mode and what the core does when it leaves. The request first passes through a synchronizer. It is then qualified over a fixed number of consecutive samples and gets one arbitration clock. It is accepted only at the end of a bus cycle, when the ready strobe is sampled low and the cycle is an I/O cycle or a memory data read.

On entry the block raises a one-clock entry strobe. It also snapshots whether the core was halted into a halt-restart slot and clears an I/O-restart slot. Handler software can read and rewrite both slots through a small register port while the core is in management mode. When the resume strobe arrives, the slots decide the result, reported on one of three one-clock outputs:
- go back to halt,
- re-run the interrupted I/O instruction,
- continue with the next instruction.

A request that qualifies while the core is already in management mode is remembered and taken after the resume.

Top module: `sysmgmt_resume_ctrl`

## Requirements
- R1: After reset, `enter`, `in_mgmt`, `resume_halt`, `resume_io` and `resume_next` are low, and both slots read as zero.
- R2: A request is taken at a ready edge only if `irq_n` was sampled low on at least the 5 preceding rising edges. This covers 2 synchronizer stages, 2 qualification samples and 1 arbitration clock. A request held only 4 edges is not taken at that edge, but it is taken at a later qualifying ready edge.
- R3: Entry happens only at a rising edge where `rdy_n` is low and `cyc_kind` is 2'b01 (I/O cycle) or 2'b10 (memory data read). Kinds 2'b00 and 2'b11 never cause entry.
- R4: `enter` is a single-cycle pulse that is high in the cycle after the accepting edge. `in_mgmt` rises at the same edge.
- R5: At entry, the halt slot (`slot_sel`=0) is loaded with `core_halted` in bit 0 and zeros elsewhere, and the I/O slot (`slot_sel`=1) is cleared to zero.
- R6: A slot write (`slot_wr` high) takes effect at the next edge while `in_mgmt` is high and is ignored otherwise. `slot_rdata` shows the selected slot combinationally.
- R7: A resume strobe while `in_mgmt` is high clears `in_mgmt` at that edge. In the next cycle it pulses `resume_halt` if halt-slot bit 0 is 1.
- R8: If halt-slot bit 0 is 0 and the I/O slot's low byte equals 8'hFF, the resume pulses `resume_io`. This holds whatever the upper byte is.
- R9: In every other case the resume pulses `resume_next`. The three resume outputs are never high together, and each is high for a single cycle.
- R10: A request that qualifies while `in_mgmt` is high causes no entry until after resume. It is then taken at the first qualifying ready edge. A request held low across a whole entry and resume counts once and causes no second entry.
- R11: A resume strobe while `in_mgmt` is low has no effect: no resume output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_n | input | 1 | Asynchronous active-low management interrupt request |
| rdy_n | input | 1 | Active-low bus-cycle ready strobe |
| cyc_kind | input | 2 | Current bus cycle kind: 00 other, 01 I/O, 10 memory data read, 11 reserved |
| core_halted | input | 1 | Core is in the halted state |
| slot_wr | input | 1 | Slot write strobe |
| slot_sel | input | 1 | Slot select: 0 halt slot, 1 I/O slot |
| slot_wdata | input | W | Slot write data |
| slot_rdata | output | W | Selected slot contents |
| resume | input | 1 | Resume command strobe |
| enter | output | 1 | One-cycle entry strobe |
| in_mgmt | output | 1 | Core is in management mode |
| resume_halt | output | 1 | Resume result: re-enter halt |
| resume_io | output | 1 | Resume result: re-run I/O instruction |
| resume_next | output | 1 | Resume result: continue with next instruction |

## Verification
`enter` is due exactly one rising edge after the accepting ready edge. That edge can fall no earlier than the sixth edge after `irq_n` goes low. Resume results are due one edge after the resume edge, and slot writes show on `slot_rdata` one edge after the write. The bench changes every input just after a falling edge, lets exactly one rising edge pass, and reads the outputs at the next falling edge. Each check therefore lands on the single cycle in which the result must appear. The cycle after each pulse is checked for the pulse having dropped.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [1:0] {
    CYC_OTHER = 2'b00,
    CYC_IO    = 2'b01,
    CYC_MEMRD = 2'b10,
    CYC_RSVD  = 2'b11
  } cyc_kind_e;

  typedef struct packed {
    logic halt;
    logic io;
    logic next;
  } outcome_t;

  localparam logic SEL_HALT = 1'b0;
  localparam logic SEL_IO   = 1'b1;

endpackage

// File: rtl/smc_rst_sync.sv
module smc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb chain_n = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_n;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/smc_req_qual.sv
module smc_req_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CLKS   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_n_i,
  output logic req_evt_o
);
  localparam int CW = $clog2(QUAL_CLKS + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(QUAL_CLKS);

  logic [SYNC_STAGES-1:0] sync_q, sync_n;
  logic [CW-1:0]          cnt_q, cnt_n;
  logic                   arb_q, arb_n;
  logic                   arb_d_q, arb_d_n;
  logic                   req_s;

  assign req_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_n  = {sync_q[SYNC_STAGES-2:0], ~irq_n_i};
    if (!req_s)                cnt_n = '0;
    else if (cnt_q == CNT_FULL) cnt_n = cnt_q;
    else                       cnt_n = cnt_q + 1'b1;
    arb_n   = (cnt_q == CNT_FULL);
    arb_d_n = arb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      cnt_q   <= '0;
      arb_q   <= 1'b0;
      arb_d_q <= 1'b0;
    end else begin
      sync_q  <= sync_n;
      cnt_q   <= cnt_n;
      arb_q   <= arb_n;
      arb_d_q <= arb_d_n;
    end
  end

  assign req_evt_o = arb_q & ~arb_d_q;

  // R2: arbitration stage only rises after the full qualification count
  a_r2_qualified_before_arb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_q) |-> $past(cnt_q) == CNT_FULL);
endmodule

// File: rtl/smc_slots.sv
module smc_slots #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         halted_i,
  input  logic         in_mgmt_i,
  input  logic         wr_i,
  input  logic         sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         halt_bit_o,
  output logic [7:0]   io_code_o
);
  import smc_pkg::*;

  logic [W-1:0] halt_q, halt_n;
  logic [W-1:0] io_q, io_n;
  logic         wr_ok;

  assign wr_ok = wr_i & in_mgmt_i;

  always_comb begin
    halt_n = halt_q;
    io_n   = io_q;
    if (clear_i) begin
      halt_n = {{(W-1){1'b0}}, halted_i};
      io_n   = '0;
    end else if (wr_ok) begin
      if (sel_i == SEL_IO) io_n   = wdata_i;
      else                 halt_n = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= '0;
      io_q   <= '0;
    end else begin
      halt_q <= halt_n;
      io_q   <= io_n;
    end
  end

  assign rdata_o    = (sel_i == SEL_IO) ? io_q : halt_q;
  assign halt_bit_o = halt_q[0];
  assign io_code_o  = io_q[7:0];

  // R5: entry snapshots the halted flag and clears the I/O slot
  a_r5_entry_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (halt_q == {{(W-1){1'b0}}, $past(halted_i)}) && (io_q == '0));

  // R6: writes outside management mode leave both slots untouched
  a_r6_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !in_mgmt_i && !clear_i) |=> $stable(halt_q) && $stable(io_q));
endmodule

// File: rtl/smc_resume_dec.sv
module smc_resume_dec #(
  parameter logic [7:0] IO_CODE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resume_i,
  input  logic              in_mgmt_i,
  input  logic              halt_bit_i,
  input  logic [7:0]        io_code_i,
  output smc_pkg::outcome_t out_o
);
  import smc_pkg::*;

  outcome_t out_q, out_n;
  logic     fire;
  logic     io_hit;

  assign fire   = resume_i & in_mgmt_i;
  assign io_hit = (io_code_i == IO_CODE);

  always_comb begin
    out_n.halt = fire & halt_bit_i;
    out_n.io   = fire & ~halt_bit_i & io_hit;
    out_n.next = fire & ~halt_bit_i & ~io_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_n;
  end

  assign out_o = out_q;

  // R9: results are mutually exclusive
  a_r9_onehot_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_q));

  // R11: resume outside management mode yields nothing
  a_r11_resume_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_i && !in_mgmt_i) |=> (out_q == '0));

  // R7: halt slot set at resume means halt re-entry
  a_r7_halt_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && halt_bit_i) |=> out_q.halt && !out_q.io);
endmodule

// File: rtl/sysmgmt_resume_ctrl.sv
module sysmgmt_resume_ctrl #(
  parameter int         W           = 16,
  parameter int         SYNC_STAGES = 2,
  parameter int         QUAL_CLKS   = 2,
  parameter logic [7:0] IO_CODE     = 8'hFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         irq_n,
  input  logic         rdy_n,
  input  logic [1:0]   cyc_kind,
  input  logic         core_halted,
  input  logic         slot_wr,
  input  logic         slot_sel,
  input  logic [W-1:0] slot_wdata,
  output logic [W-1:0] slot_rdata,
  input  logic         resume,
  output logic         enter,
  output logic         in_mgmt,
  output logic         resume_halt,
  output logic         resume_io,
  output logic         resume_next
);
  import smc_pkg::*;

  logic     srst_n;
  logic     req_evt;
  logic     pend_q, pend_n;
  logic     mgmt_q, mgmt_n;
  logic     enter_q, enter_n;
  logic     cyc_ok;
  logic     take;
  logic     halt_bit;
  logic [7:0] io_code;
  outcome_t result;

  smc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  smc_req_qual #(.SYNC_STAGES(SYNC_STAGES), .QUAL_CLKS(QUAL_CLKS)) u_qual (
    .clk(clk), .rst_n(srst_n), .irq_n_i(irq_n), .req_evt_o(req_evt)
  );

  assign cyc_ok = (cyc_kind_e'(cyc_kind) == CYC_IO) ||
                  (cyc_kind_e'(cyc_kind) == CYC_MEMRD);
  assign take   = ~mgmt_q & ~rdy_n & cyc_ok & (pend_q | req_evt);

  always_comb begin
    pend_n  = (pend_q | req_evt) & ~take;
    enter_n = take;
    mgmt_n  = mgmt_q;
    if (take)                 mgmt_n = 1'b1;
    else if (resume && mgmt_q) mgmt_n = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pend_q  <= 1'b0;
      mgmt_q  <= 1'b0;
      enter_q <= 1'b0;
    end else begin
      pend_q  <= pend_n;
      mgmt_q  <= mgmt_n;
      enter_q <= enter_n;
    end
  end

  smc_slots #(.W(W)) u_slots (
    .clk(clk), .rst_n(srst_n), .clear_i(take), .halted_i(core_halted),
    .in_mgmt_i(mgmt_q), .wr_i(slot_wr), .sel_i(slot_sel),
    .wdata_i(slot_wdata), .rdata_o(slot_rdata),
    .halt_bit_o(halt_bit), .io_code_o(io_code)
  );

  smc_resume_dec #(.IO_CODE(IO_CODE)) u_dec (
    .clk(clk), .rst_n(srst_n), .resume_i(resume), .in_mgmt_i(mgmt_q),
    .halt_bit_i(halt_bit), .io_code_i(io_code), .out_o(result)
  );

  assign enter       = enter_q;
  assign in_mgmt     = mgmt_q;
  assign resume_halt = result.halt;
  assign resume_io   = result.io;
  assign resume_next = result.next;

  // R4: entry strobe lasts one cycle and coincides with management mode
  a_r4_enter_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    enter |=> !enter);
  a_r4_enter_in_mgmt: assert property (@(posedge clk) disable iff (!srst_n)
    enter |-> in_mgmt);

  // R3: entry only after a ready edge of a qualifying cycle kind
  a_r3_cycle_kind: assert property (@(posedge clk) disable iff (!srst_n)
    enter |-> !$past(rdy_n) &&
              ($past(cyc_kind) == 2'b01 || $past(cyc_kind) == 2'b10));

  // R10: no entry while already in management mode
  a_r10_no_nested: assert property (@(posedge clk) disable iff (!srst_n)
    enter |-> !$past(in_mgmt));
endmodule

// File: tb/sim_sysmgmt_resume_ctrl.sv
module sim_sysmgmt_resume_ctrl;
  localparam int W = 16;

  logic         clk;
  logic         rst_n;
  logic         irq_n;
  logic         rdy_n;
  logic [1:0]   cyc_kind;
  logic         core_halted;
  logic         slot_wr;
  logic         slot_sel;
  logic [W-1:0] slot_wdata;
  logic [W-1:0] slot_rdata;
  logic         resume;
  logic         enter;
  logic         in_mgmt;
  logic         resume_halt;
  logic         resume_io;
  logic         resume_next;

  int nchk = 0;
  int nerr = 0;

  sysmgmt_resume_ctrl #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .rdy_n(rdy_n),
    .cyc_kind(cyc_kind), .core_halted(core_halted),
    .slot_wr(slot_wr), .slot_sel(slot_sel), .slot_wdata(slot_wdata),
    .slot_rdata(slot_rdata), .resume(resume), .enter(enter),
    .in_mgmt(in_mgmt), .resume_halt(resume_halt), .resume_io(resume_io),
    .resume_next(resume_next)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // vector: [24]halted [23]wr_halt [22]halt_val [21]wr_io [20:5]io_val [4:3]kind [2:0]exp {halt,io,next}
  localparam int NV = 8;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 2'b01, 3'b100},
    {1'b1, 1'b1, 1'b0, 1'b1, 16'h00FF, 2'b10, 3'b010},
    {1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 2'b01, 3'b001},
    {1'b0, 1'b0, 1'b0, 1'b1, 16'h00FF, 2'b10, 3'b010},
    {1'b0, 1'b0, 1'b0, 1'b1, 16'h00FE, 2'b01, 3'b001},
    {1'b1, 1'b0, 1'b0, 1'b1, 16'h00FF, 2'b10, 3'b100},
    {1'b0, 1'b0, 1'b0, 1'b1, 16'h12FF, 2'b01, 3'b010},
    {1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 2'b10, 3'b100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [2:0] res();
    return {resume_halt, resume_io, resume_next};
  endfunction

  task automatic ready_edge(input logic [1:0] kind);
    rdy_n = 1'b0; cyc_kind = kind;
    step();
    rdy_n = 1'b1; cyc_kind = 2'b00;
  endtask

  task automatic do_resume();
    resume = 1'b1;
    step();
    resume = 1'b0;
  endtask

  task automatic read_slot(input logic sel, output logic [W-1:0] v);
    slot_sel = sel;
    #1;
    v = slot_rdata;
  endtask

  task automatic write_slot(input logic sel, input logic [W-1:0] d);
    slot_wr = 1'b1; slot_sel = sel; slot_wdata = d;
    step();
    slot_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [W-1:0] rv;
    rst_n = 1'b0; irq_n = 1'b1; rdy_n = 1'b1; cyc_kind = 2'b00;
    core_halted = 1'b0; slot_wr = 1'b0; slot_sel = 1'b0;
    slot_wdata = '0; resume = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    chk("R1 enter", enter, 0);
    chk("R1 in_mgmt", in_mgmt, 0);
    chk("R1 results", res(), 0);
    read_slot(1'b0, rv); chk("R1 halt slot", rv, 0);
    read_slot(1'b1, rv); chk("R1 io slot", rv, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      core_halted = VEC[v][24];
      irq_n = 1'b0;
      step(5);                        // exactly 5 low samples (R2 boundary)
      ready_edge(VEC[v][4:3]);
      chk("R4 enter pulse", enter, 1);
      chk("R4 in_mgmt set", in_mgmt, 1);
      step();
      chk("R4 enter single", enter, 0);
      read_slot(1'b0, rv); chk("R5 halt snapshot", rv, {15'b0, VEC[v][24]});
      read_slot(1'b1, rv); chk("R5 io cleared", rv, 0);
      if (VEC[v][23]) write_slot(1'b0, {15'b0, VEC[v][22]});
      if (VEC[v][21]) begin
        write_slot(1'b1, VEC[v][20:5]);
        read_slot(1'b1, rv); chk("R6 io write", rv, VEC[v][20:5]);
      end
      do_resume();
      chk("R7 R8 R9 result", res(), VEC[v][2:0]);
      chk("R7 in_mgmt cleared", in_mgmt, 0);
      step();
      chk("R9 result single", res(), 0);
      ready_edge(2'b01);
      chk("R10 held request once", enter, 0);
      irq_n = 1'b1;
      step(6);
    end

    // R2: only 4 low samples before ready -> not taken, taken later
    core_halted = 1'b0;
    irq_n = 1'b0;
    step(4);
    ready_edge(2'b01);
    chk("R2 too early", enter, 0);
    step(2);
    ready_edge(2'b01);
    chk("R2 later ready", enter, 1);
    step();
    do_resume();
    chk("R9 next", res(), 3'b001);
    irq_n = 1'b1;
    step(6);

    // R3: non-qualifying cycle kinds
    irq_n = 1'b0;
    step(5);
    ready_edge(2'b00);
    chk("R3 kind 00", enter, 0);
    ready_edge(2'b11);
    chk("R3 kind 11", enter, 0);
    ready_edge(2'b10);
    chk("R3 kind 10", enter, 1);
    step();
    do_resume();
    irq_n = 1'b1;
    step(6);

    // R10: request during management mode is held pending
    irq_n = 1'b0;
    step(5);
    ready_edge(2'b01);
    chk("R10 first entry", enter, 1);
    irq_n = 1'b1;
    step(6);
    irq_n = 1'b0;
    step(6);
    irq_n = 1'b1;
    ready_edge(2'b01);
    chk("R10 no nested entry", enter, 0);
    chk("R10 still in mgmt", in_mgmt, 1);
    do_resume();
    chk("R10 resumed", in_mgmt, 0);
    ready_edge(2'b01);
    chk("R10 pending taken", enter, 1);
    step();
    do_resume();
    step(6);

    // R6 writes outside management mode, R11 resume outside
    write_slot(1'b1, 16'hFFFF);
    read_slot(1'b1, rv); chk("R6 io write ignored", rv, 0);
    write_slot(1'b0, 16'h0001);
    read_slot(1'b0, rv); chk("R6 halt write ignored", rv, 0);
    do_resume();
    chk("R11 no result", res(), 0);
    chk("R11 in_mgmt low", in_mgmt, 0);
    step();
    chk("R11 still no result", res(), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule